// File: doc/BRIEF.md
# Time-Multiplexed Multiport RAM

This block gives a single one-write/one-read synchronous RAM the appearance of P independent ports. Every port offers an address, write data and a write enable on the system clock, and every port has its own read-data output. The RAM itself runs on an internal clock that is exactly P times the system clock and rises together with it. Inside each system cycle the P ports are served one after another, one per internal cycle, in a fixed order from port 0 to port P-1.

Requests are captured on a system edge. During the next system cycle a rotation counter steps through the ports and presents each captured request to the RAM in turn. Read results are collected on the internal clock and then moved onto system-clock output registers. All ports see the same latency.

The order in which the ports are served also sets the result when requests collide. A later port sees writes from earlier ports in the same cycle, and when two ports write the same address, the later port's value stays in the RAM.

Top module: `mpm_multiport_ram`

## Requirements
- R1: While reset is high, and on the first system cycle after it is released, every read-data output is zero.
- R2: A request sampled on system edge n produces its read data on that port's output right after system edge n+2, and the output holds that value until the next system edge.
- R3: All P ports can read different addresses in the same system cycle, and each port receives the content of its own address.
- R4: A write (write enable bit k high for port k) stores its data, and every port reading that address in a later system cycle receives it.
- R5: A port that writes returns, on its own read-data output, the content the address held just before its write.
- R6: When several ports write one address in the same system cycle, the highest-numbered of those ports leaves its value in the RAM.
- R7: Port j reading an address in the same system cycle that port i writes it receives the new value when i < j and the previous value when i > j.
- R8: A port whose write enable bit is low changes no RAM content, whatever its write data.
- R9: The rotation counter is zero during reset, serves port 0 on the first internal edge after each system edge, advances by one on every internal edge, and reaches P-1 on the internal edge that coincides with the system edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock. Requests are sampled and results are presented on its rising edge. |
| clk_int | input | 1 | Internal clock, P times the system clock, rising edges aligned with clk_sys. |
| rst | input | 1 | Synchronous active-high reset. Release it just after a system rising edge. |
| port_addr | input | P*AW | Address of port k in bits [k*AW +: AW]. |
| port_wdata | input | P*DW | Write data of port k in bits [k*DW +: DW]. |
| port_we | input | P | Write enable. Bit k belongs to port k. |
| port_rdata | output | P*DW | Read data of port k in bits [k*DW +: DW]. |

## Verification
The bench focuses on conflicts inside a single system cycle. It drives several ports writing one address, which a design with reversed priority or a different rotation order would resolve to the wrong value. It also drives reads that share an address with writes from ports before and after them in the rotation, which a design that reads a whole cycle's results in one snapshot would get wrong. Back-to-back cycles with changing addresses are compared cycle-exactly, so a port whose result is realigned one system cycle early or late shows stale or future data. Writes with the enable low but with non-zero data are read back to show that a missing enable qualifier corrupts memory.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    // Bits needed to number the rotation slots (at least one).
    function automatic int unsigned slot_bits(input int unsigned ports);
        return (ports > 1) ? $clog2(ports) : 1;
    endfunction

    // Port counts must be powers of two so the slot counter wraps by itself.
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/mpm_capture.sv
module mpm_capture #(
    parameter int P  = 4,
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic            clk_sys,
    input  logic            rst,
    input  logic [P*AW-1:0] in_addr,
    input  logic [P*DW-1:0] in_wdata,
    input  logic [P-1:0]    in_we,
    output logic [P*AW-1:0] cap_addr,
    output logic [P*DW-1:0] cap_wdata,
    output logic [P-1:0]    cap_we
);
    // Requests are held for a whole system cycle while the rotation walks them.
    always_ff @(posedge clk_sys) begin
        if (rst) begin
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_we    <= '0;
        end else begin
            cap_addr  <= in_addr;
            cap_wdata <= in_wdata;
            cap_we    <= in_we;
        end
    end
endmodule

// File: rtl/mpm_rotor.sv
module mpm_rotor #(
    parameter int P  = 4,
    parameter int CW = 2
) (
    input  logic          clk_int,
    input  logic          rst,
    output logic [CW-1:0] slot
);
    // Power-of-two P: the counter wraps at P without compare logic.
    always_ff @(posedge clk_int) begin
        if (rst) slot <= '0;
        else     slot <= slot + 1'b1;
    end
endmodule

// File: rtl/mpm_ram.sv
module mpm_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk_int,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_word
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk_int) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // Sampled by the realignment register on the same edge as the write,
    // so a slot sees the word as it was before its own write.
    assign rd_word = mem[addr];
endmodule

// File: rtl/mpm_realign.sv
module mpm_realign #(
    parameter int P  = 4,
    parameter int DW = 8,
    parameter int CW = 2
) (
    input  logic            clk_int,
    input  logic            clk_sys,
    input  logic            rst,
    input  logic [CW-1:0]   slot,
    input  logic [DW-1:0]   rd_word,
    output logic [P*DW-1:0] port_rdata
);
    logic [DW-1:0] hold_q [P];

    // Demultiplex: the served slot's word lands in its own holding register.
    always_ff @(posedge clk_int) begin
        if (rst) begin
            for (int k = 0; k < P; k++) hold_q[k] <= '0;
        end else begin
            hold_q[slot] <= rd_word;
        end
    end

    // Slots 0..P-2 finish before the system edge and need one extra stage;
    // the last slot finishes on the system edge itself and its hold register
    // stays valid for a full system cycle.
    for (genvar k = 0; k < P; k++) begin : g_port
        if (k == P - 1) begin : g_last
            logic [DW-1:0] out_q;
            always_ff @(posedge clk_sys) begin
                if (rst) out_q <= '0;
                else     out_q <= hold_q[k];
            end
            assign port_rdata[k*DW +: DW] = out_q;
        end else begin : g_staged
            logic [DW-1:0] stage_q;
            logic [DW-1:0] out_q;
            always_ff @(posedge clk_sys) begin
                if (rst) begin
                    stage_q <= '0;
                    out_q   <= '0;
                end else begin
                    stage_q <= hold_q[k];
                    out_q   <= stage_q;
                end
            end
            assign port_rdata[k*DW +: DW] = out_q;
        end
    end
endmodule

// File: rtl/mpm_multiport_ram.sv
module mpm_multiport_ram #(
    parameter int P     = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk_sys,
    input  logic                         clk_int,
    input  logic                         rst,
    input  logic [P*$clog2(DEPTH)-1:0]   port_addr,
    input  logic [P*DW-1:0]              port_wdata,
    input  logic [P-1:0]                 port_we,
    output logic [P*DW-1:0]              port_rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = mpm_pkg::slot_bits(P);

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_req_t;

    logic [P*AW-1:0] cap_addr;
    logic [P*DW-1:0] cap_wdata;
    logic [P-1:0]    cap_we;
    logic [CW-1:0]   slot;
    slot_req_t       sel;
    logic [DW-1:0]   rd_word;

    mpm_capture #(.P(P), .AW(AW), .DW(DW)) u_capture (
        .clk_sys   (clk_sys),
        .rst       (rst),
        .in_addr   (port_addr),
        .in_wdata  (port_wdata),
        .in_we     (port_we),
        .cap_addr  (cap_addr),
        .cap_wdata (cap_wdata),
        .cap_we    (cap_we)
    );

    mpm_rotor #(.P(P), .CW(CW)) u_rotor (
        .clk_int (clk_int),
        .rst     (rst),
        .slot    (slot)
    );

    // Port multiplexer: the slot number picks which captured request drives the RAM.
    always_comb begin
        sel.we   = cap_we[slot];
        sel.addr = cap_addr[slot*AW +: AW];
        sel.data = cap_wdata[slot*DW +: DW];
    end

    mpm_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
        .clk_int (clk_int),
        .wr_en   (sel.we & ~rst),
        .addr    (sel.addr),
        .wdata   (sel.data),
        .rd_word (rd_word)
    );

    mpm_realign #(.P(P), .DW(DW), .CW(CW)) u_realign (
        .clk_int    (clk_int),
        .clk_sys    (clk_sys),
        .rst        (rst),
        .slot       (slot),
        .rd_word    (rd_word),
        .port_rdata (port_rdata)
    );
endmodule

// File: rtl/mpm_multiport_ram_chk.sv
module mpm_multiport_ram_chk #(
    parameter int P    = 4,
    parameter int CW   = 2,
    parameter int CAPW = 8,
    parameter int OW   = 8
) (
    input logic            clk_sys,
    input logic            clk_int,
    input logic            rst,
    input logic [CW-1:0]   slot,
    input logic [CAPW-1:0] cap_bus,
    input logic [OW-1:0]   port_rdata
);
    // R9: the system edge coincides with the last slot of the rotation.
    assert_phase_R9: assert property (@(posedge clk_sys) disable iff (rst)
        slot == CW'(P - 1));

    // R9: one step per internal edge, wrapping from P-1 to 0.
    assert_step_R9: assert property (@(posedge clk_int) disable iff (rst)
        1'b1 |=> (slot == CW'($past(slot) + 1'b1)));

    // R2: outputs move only on the internal edge shared with the system edge.
    assert_out_stable_R2: assert property (@(posedge clk_int) disable iff (rst)
        (slot != '0) |-> $stable(port_rdata));

    // R3: the captured requests stay put while the rotation serves them.
    assert_cap_hold_R3: assert property (@(posedge clk_int) disable iff (rst)
        (slot != '0) |-> $stable(cap_bus));
endmodule

bind mpm_multiport_ram mpm_multiport_ram_chk #(
    .P    (P),
    .CW   (CW),
    .CAPW (P * (1 + AW + DW)),
    .OW   (P * DW)
) u_chk (
    .clk_sys    (clk_sys),
    .clk_int    (clk_int),
    .rst        (rst),
    .slot       (slot),
    .cap_bus    ({cap_we, cap_addr, cap_wdata}),
    .port_rdata (port_rdata)
);

// File: tb/tb_mpm_multiport_ram.sv
module tb_mpm_multiport_ram;
    timeunit 1ns;
    timeprecision 10ps;

    localparam int P     = 4;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;

    logic            clk_sys, clk_int, rst;
    logic [P*AW-1:0] port_addr;
    logic [P*DW-1:0] port_wdata;
    logic [P-1:0]    port_we;
    logic [P*DW-1:0] port_rdata;

    mpm_multiport_ram #(.P(P), .DEPTH(DEPTH), .DW(DW)) dut (
        .clk_sys    (clk_sys),
        .clk_int    (clk_int),
        .rst        (rst),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_we    (port_we),
        .port_rdata (port_rdata)
    );

    // One process makes both clocks: 1 ns internal, 4 ns (250 MHz) system.
    int ph;
    initial begin
        clk_int = 0;
        clk_sys = 0;
        ph = 2 * P - 1;
        forever begin
            #0.5;
            ph = (ph + 1) % (2 * P);
            clk_int = (ph % 2 == 0);
            clk_sys = (ph < P);
        end
    end

    int cyc = 0;
    always @(posedge clk_sys) cyc = cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int              due;
        logic [P*DW-1:0] exp;
        string           tag;
    } item_t;
    item_t sb[$];

    logic [DW-1:0] model [DEPTH];

    task automatic check_port(input int k, input logic [DW-1:0] act,
                              input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port %0d actual %h expected %h", tag, k, act, exp);
        end
    endtask

    // Driver: drive on the falling edge, predict from the serving order,
    // push the expectation due right after the second following system edge.
    task automatic issue(input logic [P*AW-1:0] a, input logic [P*DW-1:0] d,
                         input logic [P-1:0] w, input string tag, input bit chk);
        item_t it;
        @(negedge clk_sys);
        port_addr  = a;
        port_wdata = d;
        port_we    = w;
        it.exp = '0;
        for (int k = 0; k < P; k++) begin
            int ad;
            ad = int'(a[k*AW +: AW]);
            it.exp[k*DW +: DW] = model[ad];
            if (w[k]) model[ad] = d[k*DW +: DW];
        end
        it.due = cyc + 3;
        it.tag = tag;
        if (chk) sb.push_back(it);
    endtask

    function automatic logic [P*AW-1:0] pa(input int a0, a1, a2, a3);
        return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
    endfunction
    function automatic logic [P*DW-1:0] pd(input int d0, d1, d2, d3);
        return {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    endfunction

    // Monitor: pop and compare each expectation in the cycle it falls due.
    always @(negedge clk_sys) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            for (int k = 0; k < P; k++)
                check_port(k, port_rdata[k*DW +: DW], it.exp[k*DW +: DW], it.tag);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue('0, '0, '0, "idle", 0);
    endtask

    initial begin
        int unsigned rs;
        rst = 1;
        port_addr = '0;
        port_wdata = '0;
        port_we = '0;
        repeat (3) @(posedge clk_sys);
        @(negedge clk_sys);
        for (int k = 0; k < P; k++)
            check_port(k, port_rdata[k*DW +: DW], '0, "R1 in reset");
        @(posedge clk_sys);
        #0.1 rst = 0;
        @(negedge clk_sys);
        for (int k = 0; k < P; k++)
            check_port(k, port_rdata[k*DW +: DW], '0, "R1 after release");

        // Fill the whole RAM, four addresses per cycle (contents before unknown).
        for (int c = 0; c < DEPTH / P; c++)
            issue(pa(4*c, 4*c+1, 4*c+2, 4*c+3),
                  pd(13*(4*c)+33, 13*(4*c+1)+33, 13*(4*c+2)+33, 13*(4*c+3)+33),
                  4'b1111, "fill", 0);

        // R3/R4: parallel reads of distinct addresses, several patterns, back to back (R2).
        issue(pa(0, 5, 10, 15), '0, 4'b0000, "R3 R4 read A", 1);
        issue(pa(3, 2, 1, 0),   '0, 4'b0000, "R3 R4 read B", 1);
        issue(pa(7, 7, 12, 8),  '0, 4'b0000, "R2 R3 read C", 1);
        issue(pa(14, 9, 6, 11), '0, 4'b0000, "R2 R3 read D", 1);

        // R5: writing ports return the old content.
        issue(pa(5, 6, 4, 13), pd(8'hA5, 8'h5A, 8'hC3, 8'h3C), 4'b0101, "R5 write old", 1);
        issue(pa(5, 6, 4, 13), '0, 4'b0000, "R4 readback", 1);

        // R6: ports 0 and 3 (and then 1 and 2) write one address.
        issue(pa(7, 2, 3, 7), pd(8'h11, 8'h22, 8'h33, 8'h44), 4'b1001, "R6 collide 0/3", 1);
        issue(pa(1, 7, 7, 1), pd(8'h55, 8'h66, 8'h77, 8'h88), 4'b0110, "R6 collide 1/2", 1);
        issue(pa(7, 1, 7, 0), '0, 4'b0000, "R6 winner", 1);

        // R7: order within one system cycle.
        issue(pa(9, 10, 9, 10), pd(8'hAA, 8'h00, 8'h00, 8'hBB), 4'b1001, "R7 order", 1);
        issue(pa(10, 9, 2, 12), pd(8'h00, 8'h00, 8'h9C, 8'h00), 4'b0100, "R7 order 2", 1);
        issue(pa(2, 2, 10, 2), pd(8'h01, 8'h00, 8'h00, 8'h00), 4'b0001, "R7 read after", 1);

        // R8: write data with enable low must not land.
        issue(pa(0, 1, 2, 3), pd(8'hDE, 8'hAD, 8'hBE, 8'hEF), 4'b0000, "R8 no enable", 1);
        issue(pa(0, 1, 2, 3), '0, 4'b0000, "R8 readback", 1);

        // Mixed pseudo-random traffic.
        rs = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            logic [P*AW-1:0] a;
            logic [P*DW-1:0] d;
            logic [P-1:0] w;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            a = rs[P*AW-1:0];
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            d = rs[P*DW-1:0];
            w = rs[P-1:0] & rs[P+3:4];
            issue(a, d, w, "R3 R7 mixed", 1);
        end

        idle(4);
        repeat (2) @(negedge clk_sys);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule